// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block produces the frame-level timing strobes for a T1 transmitter. It runs on the 1.544 MHz transmit line clock and keeps a bit position (0 to 192) and a frame number within the multiframe. Bit 0 is the framing bit. Channels 1 to 24 follow, eight bits each, and the least significant bit of a channel is its last bit. From this single position it derives a channel clock, a per-channel blocking output, a demand clock for the data-link input and a frame or multiframe sync pulse. During the framing slots that carry link data, it captures one link bit.

The sync terminal is either an input or an output. As an input, a pulse realigns the counters to a frame boundary or to a multiframe boundary. As an output, it marks every frame, or only the first frame of each multiframe. In the every-frame mode, the pulse can be widened to two bits on signaling frames. The multiframe length and the frames that carry link bits depend on the selected framing format.

Top module: `t1_tx_frame_timer`

## Requirements
- R1: The bit index counts 0 to 192 and then returns to 0. Each return to 0 advances the frame index. A frame index equal to or above the multiframe length goes back to 1 instead. The multiframe length is 12 frames for `fmt_sel`=0 (D4) and 24 frames for `fmt_sel`=1 (ESF), 2 (ZBTSI) and 3 (same as ESF).
- R2: `chan_clk` is high exactly at bit indices 8, 16, ..., 192, which are the LSB of each channel.
- R3: Bit c of the channel mask (c=0..23) is channel c+1, which covers bit indices 8c+1 to 8c+8. `chan_blk` is high during those bits when the mask bit is 1 and low otherwise. It is always low at bit 0. A write through `mask_we`/`mask_wdata` at one rising edge takes effect from the next rising edge on.
- R4: `link_clk` is high for one bit, at bit 192 of the frame that comes before a link frame. Link frames are the odd frames in ESF, the even frames in D4 and the multiples of 4 in ZBTSI.
- R5: When `link_en` is high at the framing bit (bit 0) of a link frame, `link_din` is captured into `link_bit` and `link_stb` pulses for one cycle. Both are seen in the cycle after that bit. With `link_en` low there is no strobe and `link_bit` holds its value.
- R6: With `sync_drive`=1 and `sync_mf`=0, `sync_out` is high at bit 0 of every frame.
- R7: In the R6 mode with `sync_dbl`=1, `sync_out` is also high at bit 1 of frames 6, 12, 18 and 24.
- R8: With `sync_drive`=1 and `sync_mf`=1, `sync_out` is high only at bit 0 of frame 1.
- R9: With `sync_drive`=0, `sync_out` stays low. A high `sync_in` at a rising edge sets the next position to bit 0. The frame becomes 1 when `sync_mf`=1, and the following frame (as at a normal frame end) when `sync_mf`=0.
- R10: With `sync_drive`=1, `sync_in` has no effect on the counters.
- R11: While reset is held, the bit index is 192, the frame index is 24, the mask is clear and every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing format: 0 D4, 1 ESF, 2 ZBTSI, 3 ESF |
| sync_drive | input | 1 | 1: sync is an output, 0: sync is an input |
| sync_mf | input | 1 | Sync acts on multiframe (1) or frame (0) boundary |
| sync_dbl | input | 1 | Two-bit sync pulse on signaling frames |
| sync_in | input | 1 | External sync pulse |
| link_en | input | 1 | Enables link bit capture |
| link_din | input | 1 | Link data |
| mask_we | input | 1 | Channel mask write strobe |
| mask_wdata | input | 24 | Channel mask write value |
| sync_out | output | 1 | Generated sync pulse |
| chan_clk | output | 1 | Channel LSB strobe |
| chan_blk | output | 1 | Per-channel block output |
| link_clk | output | 1 | Link data demand clock |
| link_bit | output | 1 | Last captured link bit |
| link_stb | output | 1 | Link capture strobe |
| bit_idx | output | 8 | Current bit position |
| frame_idx | output | 5 | Current frame number |

## Verification
The strobes are decoded from the next counter state and registered at the same edge as the counters. So `bit_idx`, `frame_idx`, `chan_clk`, `chan_blk`, `link_clk` and `sync_out` all describe the same position in the cycle after each rising edge. The link capture is due one cycle after the framing bit it samples, and a mask write shows on `chan_blk` from the second edge after it is presented. The bench model advances its own position at every rising edge, using the inputs that were held across that edge. It then compares all outputs at the following falling edge, with the capture and mask latencies built into the model.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;

  localparam int CHANNELS    = 24;
  localparam int BITS_PER_CH = 8;
  localparam int FRAME_BITS  = 1 + CHANNELS * BITS_PER_CH;
  localparam int BIT_W       = $clog2(FRAME_BITS);
  localparam int ESF_FRAMES  = 24;
  localparam int D4_FRAMES   = 12;
  localparam int FRM_W       = $clog2(ESF_FRAMES + 1);
  localparam int SIG_PERIOD  = 6;
  localparam int ZB_PERIOD   = 4;

  typedef logic [BIT_W-1:0] bit_idx_t;
  typedef logic [FRM_W-1:0] frm_idx_t;

  typedef enum logic [1:0] {
    FMT_D4  = 2'd0,
    FMT_ESF = 2'd1,
    FMT_ZBT = 2'd2,
    FMT_ALT = 2'd3
  } fmt_e;

  // Frames in one multiframe for a given format.
  function automatic frm_idx_t mf_len(fmt_e f);
    return (f == FMT_D4) ? FRM_W'(D4_FRAMES) : FRM_W'(ESF_FRAMES);
  endfunction

  // Frame that follows fr, with multiframe wrap.
  function automatic frm_idx_t frm_succ(frm_idx_t fr, fmt_e f);
    return (fr >= mf_len(f)) ? FRM_W'(1) : fr + FRM_W'(1);
  endfunction

  // Frames whose framing bit carries link data.
  function automatic logic link_slot(frm_idx_t fr, fmt_e f);
    logic hit;
    case (f)
      FMT_D4:  hit = ~fr[0];
      FMT_ZBT: hit = ((fr % FRM_W'(ZB_PERIOD)) == '0);
      default: hit = fr[0];
    endcase
    return hit;
  endfunction

  function automatic logic sig_frame(frm_idx_t fr);
    return (fr != '0) && ((fr % FRM_W'(SIG_PERIOD)) == '0);
  endfunction

endpackage

// File: rtl/t1_tx_frame_counter.sv
module t1_tx_frame_counter
  import t1_tx_pkg::*;
#(
  parameter int FRAME_LEN  = FRAME_BITS,
  parameter int MAX_FRAMES = ESF_FRAMES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  fmt_e     fmt,
  input  logic     sync_load,
  input  logic     sync_to_mf,
  output bit_idx_t bit_q,
  output frm_idx_t frm_q,
  output bit_idx_t bit_nxt,
  output frm_idx_t frm_nxt
);

  localparam bit_idx_t LAST_BIT = bit_idx_t'(FRAME_LEN - 1);
  localparam frm_idx_t TOP_FRM  = frm_idx_t'(MAX_FRAMES);

  frm_idx_t frm_step;

  always_comb begin
    frm_step = frm_succ(frm_q, fmt);
    bit_nxt  = bit_q + bit_idx_t'(1);
    frm_nxt  = frm_q;
    if (sync_load) begin
      bit_nxt = '0;
      frm_nxt = sync_to_mf ? frm_idx_t'(1) : frm_step;
    end else if (bit_q == LAST_BIT) begin
      bit_nxt = '0;
      frm_nxt = frm_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= LAST_BIT;
      frm_q <= TOP_FRM;
    end else begin
      bit_q <= bit_nxt;
      frm_q <= frm_nxt;
    end
  end

  assert_bit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= LAST_BIT);

  assert_frame_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q != '0) && (frm_q <= TOP_FRM));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q == LAST_BIT && !sync_load) |=> (bit_q == '0 && frm_q != $past(frm_q)));

  assert_mf_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_load && sync_to_mf) |=> (bit_q == '0 && frm_q == frm_idx_t'(1)));

endmodule

// File: rtl/t1_tx_chan_mask.sv
module t1_tx_chan_mask #(
  parameter int CH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CH-1:0] wdata,
  output logic [CH-1:0] mask_q
);

  logic [CH-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/t1_tx_strobe_gen.sv
module t1_tx_strobe_gen
  import t1_tx_pkg::*;
#(
  parameter int CH        = CHANNELS,
  parameter int BPC       = BITS_PER_CH,
  parameter int FRAME_LEN = FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  bit_idx_t      bit_nxt,
  input  frm_idx_t      frm_nxt,
  input  logic [CH-1:0] mask,
  input  logic          sync_drv,
  input  logic          sync_mf,
  input  logic          sync_dbl,
  output logic          chan_clk_q,
  output logic          chan_blk_q,
  output logic          link_clk_q,
  output logic          sync_out_q
);

  localparam bit_idx_t LAST_BIT = bit_idx_t'(FRAME_LEN - 1);

  logic [CH-1:0] in_ch;
  logic [CH-1:0] lsb_hit;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    localparam int FIRST_B = 1 + c * BPC;
    localparam int LAST_B  = (c + 1) * BPC;
    assign in_ch[c]   = (bit_nxt >= bit_idx_t'(FIRST_B)) && (bit_nxt <= bit_idx_t'(LAST_B));
    assign lsb_hit[c] = (bit_nxt == bit_idx_t'(LAST_B));
  end

  logic     is_fbit;
  frm_idx_t frm_after;
  logic     cclk_d, blk_d, lclk_d, sync_d;

  always_comb begin
    is_fbit   = (bit_nxt == '0);
    frm_after = frm_succ(frm_nxt, fmt);
    cclk_d    = |lsb_hit;
    blk_d     = |(in_ch & mask);
    lclk_d    = (bit_nxt == LAST_BIT) && link_slot(frm_after, fmt);
    if (!sync_drv) begin
      sync_d = 1'b0;
    end else if (sync_mf) begin
      sync_d = is_fbit && (frm_nxt == frm_idx_t'(1));
    end else begin
      sync_d = is_fbit || (sync_dbl && bit_nxt == bit_idx_t'(1) && sig_frame(frm_nxt));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_clk_q <= 1'b0;
      chan_blk_q <= 1'b0;
      link_clk_q <= 1'b0;
      sync_out_q <= 1'b0;
    end else begin
      chan_clk_q <= cclk_d;
      chan_blk_q <= blk_d;
      link_clk_q <= lclk_d;
      sync_out_q <= sync_d;
    end
  end

  assert_lsb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk_q |=> !chan_clk_q);

  assert_link_clk_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk_q |=> !link_clk_q);

  assert_sync_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_drv |=> !sync_out_q);

endmodule

// File: rtl/t1_tx_link_capture.sv
module t1_tx_link_capture
  import t1_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fmt_e     fmt,
  input  bit_idx_t bit_q,
  input  frm_idx_t frm_q,
  input  logic     link_en,
  input  logic     link_din,
  output logic     link_bit_q,
  output logic     link_stb_q
);

  logic take;
  logic bit_d;

  always_comb begin
    take  = link_en && (bit_q == '0) && link_slot(frm_q, fmt);
    bit_d = take ? link_din : link_bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_bit_q <= 1'b0;
      link_stb_q <= 1'b0;
    end else begin
      link_bit_q <= bit_d;
      link_stb_q <= take;
    end
  end

  assert_stb_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_stb_q |-> $past(link_en));

endmodule

// File: rtl/t1_tx_frame_timer.sv
module t1_tx_frame_timer
  import t1_tx_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic                sync_drive,
  input  logic                sync_mf,
  input  logic                sync_dbl,
  input  logic                sync_in,
  input  logic                link_en,
  input  logic                link_din,
  input  logic                mask_we,
  input  logic [CHANNELS-1:0] mask_wdata,
  output logic                sync_out,
  output logic                chan_clk,
  output logic                chan_blk,
  output logic                link_clk,
  output logic                link_bit,
  output logic                link_stb,
  output logic [BIT_W-1:0]    bit_idx,
  output logic [FRM_W-1:0]    frame_idx
);

  // Reset asserts asynchronously and is released on a clock edge.
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[RST_STAGES-1];

  fmt_e          fmt;
  logic          sync_load;
  bit_idx_t      bit_q, bit_nxt;
  frm_idx_t      frm_q, frm_nxt;
  logic [CHANNELS-1:0] mask_q;

  assign fmt       = fmt_e'(fmt_sel);
  assign sync_load = !sync_drive && sync_in;

  t1_tx_frame_counter #(
    .FRAME_LEN  (FRAME_BITS),
    .MAX_FRAMES (ESF_FRAMES)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fmt        (fmt),
    .sync_load  (sync_load),
    .sync_to_mf (sync_mf),
    .bit_q      (bit_q),
    .frm_q      (frm_q),
    .bit_nxt    (bit_nxt),
    .frm_nxt    (frm_nxt)
  );

  t1_tx_chan_mask #(.CH(CHANNELS)) u_mask (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .we     (mask_we),
    .wdata  (mask_wdata),
    .mask_q (mask_q)
  );

  t1_tx_strobe_gen #(
    .CH        (CHANNELS),
    .BPC       (BITS_PER_CH),
    .FRAME_LEN (FRAME_BITS)
  ) u_strb (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fmt        (fmt),
    .bit_nxt    (bit_nxt),
    .frm_nxt    (frm_nxt),
    .mask       (mask_q),
    .sync_drv   (sync_drive),
    .sync_mf    (sync_mf),
    .sync_dbl   (sync_dbl),
    .chan_clk_q (chan_clk),
    .chan_blk_q (chan_blk),
    .link_clk_q (link_clk),
    .sync_out_q (sync_out)
  );

  t1_tx_link_capture u_link (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fmt        (fmt),
    .bit_q      (bit_q),
    .frm_q      (frm_q),
    .link_en    (link_en),
    .link_din   (link_din),
    .link_bit_q (link_bit),
    .link_stb_q (link_stb)
  );

  assign bit_idx   = bit_q;
  assign frame_idx = frm_q;

  assert_sync_ignored_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sync_drive && bit_q != bit_idx_t'(FRAME_BITS - 1)) |=> (bit_q == $past(bit_q) + bit_idx_t'(1)));

endmodule

// File: tb/t1_tx_frame_timer_tb.sv
`timescale 1ns/1ps
module t1_tx_frame_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic        sync_drive, sync_mf, sync_dbl, sync_in;
  logic        link_en, link_din, mask_we;
  logic [23:0] mask_wdata;
  logic        sync_out, chan_clk, chan_blk, link_clk, link_bit, link_stb;
  logic [7:0]  bit_idx;
  logic [4:0]  frame_idx;

  always #2 clk = ~clk;

  t1_tx_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sync_drive(sync_drive),
    .sync_mf(sync_mf), .sync_dbl(sync_dbl), .sync_in(sync_in),
    .link_en(link_en), .link_din(link_din), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .sync_out(sync_out), .chan_clk(chan_clk),
    .chan_blk(chan_blk), .link_clk(link_clk), .link_bit(link_bit),
    .link_stb(link_stb), .bit_idx(bit_idx), .frame_idx(frame_idx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit aligned = 0;

  // Reference state
  int mb = 0, mf = 1;
  logic [23:0] mmask = '0;
  logic e_cclk, e_blk, e_lclk, e_sync, e_lbit = 1'b0, e_stb = 1'b0;

  function automatic int mflen(int f);
    return (f == 0) ? 12 : 24;
  endfunction

  function automatic bit slot(int fr, int f);
    if (f == 0) return (fr % 2) == 0;
    if (f == 2) return (fr % 4) == 0;
    return (fr % 2) == 1;
  endfunction

  function automatic int nxt_frame(int fr, int f);
    return (fr >= mflen(f)) ? 1 : fr + 1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (bit %0d frame %0d)", tag, what, act, exp_v, mb, mf);
    end
  endtask

  task automatic model();
    int f;
    f = int'(fmt_sel);
    e_stb = link_en && mb == 0 && slot(mf, f);
    if (e_stb) e_lbit = link_din;
    if (!sync_drive && sync_in) begin
      mb = 0;
      mf = sync_mf ? 1 : nxt_frame(mf, f);
    end else if (mb == 192) begin
      mb = 0;
      mf = nxt_frame(mf, f);
    end else begin
      mb++;
    end
    e_cclk = (mb != 0) && (mb % 8 == 0);
    e_blk  = (mb != 0) && mmask[(mb - 1) / 8];
    e_lclk = (mb == 192) && slot(nxt_frame(mf, f), f);
    if (!sync_drive)  e_sync = 1'b0;
    else if (sync_mf) e_sync = (mb == 0) && (mf == 1);
    else              e_sync = (mb == 0) || (sync_dbl && mb == 1 && (mf % 6 == 0));
    if (mask_we) mmask = mask_wdata;
  endtask

  task automatic compare();
    chk("R1", "bit_idx", int'(bit_idx), mb);
    chk("R1", "frame_idx", int'(frame_idx), mf);
    chk("R2", "chan_clk", int'(chan_clk), int'(e_cclk));
    chk("R3", "chan_blk", int'(chan_blk), int'(e_blk));
    chk("R4", "link_clk", int'(link_clk), int'(e_lclk));
    chk("R5", "link_stb", int'(link_stb), int'(e_stb));
    chk("R5", "link_bit", int'(link_bit), int'(e_lbit));
    if (!sync_drive)
      chk("R9", "sync_out", int'(sync_out), int'(e_sync));
    else if (sync_mf)
      chk("R8", "sync_out", int'(sync_out), int'(e_sync));
    else if (sync_dbl)
      chk("R7", "sync_out", int'(sync_out), int'(e_sync));
    else
      chk("R6", "sync_out", int'(sync_out), int'(e_sync));
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    if (aligned) compare();
  endtask

  task automatic rand_cycles(input int n, input int sync_rate, input bit en_rand);
    for (int i = 0; i < n; i++) begin
      link_din = 1'($urandom);
      if (en_rand && ($urandom % 50) == 0) link_en = ~link_en;
      mask_we = ($urandom % 300) == 0;
      mask_wdata = 24'($urandom);
      sync_in = (sync_rate != 0) && (($urandom % sync_rate) == 0);
      if (sync_drive == 1'b0 && sync_in) sync_mf = 1'($urandom);
      step();
    end
    sync_in = 1'b0;
    mask_we = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1544));
    rst_n = 1'b0;
    fmt_sel = 2'd1; sync_drive = 1'b0; sync_mf = 1'b1; sync_dbl = 1'b0;
    sync_in = 1'b0; link_en = 1'b0; link_din = 1'b0; mask_we = 1'b0; mask_wdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11", "bit_idx", int'(bit_idx), 192);
    chk("R11", "frame_idx", int'(frame_idx), 24);
    chk("R11", "strobes", int'({sync_out, chan_clk, chan_blk, link_clk, link_bit, link_stb}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Align the reference with a multiframe sync pulse (R9)
    sync_in = 1'b1; sync_mf = 1'b1;
    step();
    aligned = 1;
    sync_in = 1'b0;
    compare();
    // R3: mask still clear through a whole frame
    repeat (200) step();

    // R6/R7 in ESF with link capture
    sync_drive = 1'b1; sync_mf = 1'b0; sync_dbl = 1'b1; link_en = 1'b1;
    mask_we = 1'b1; mask_wdata = 24'h800001;
    step();
    mask_we = 1'b0;
    rand_cycles(9000, 0, 1'b0);
    // Directed: switch to D4 at frame 20 so the frame index wraps (R1)
    while (!(mf == 20 && mb == 100)) step();
    fmt_sel = 2'd0; sync_mf = 1'b1;
    rand_cycles(6000, 0, 1'b1);

    // ZBTSI, plain frame pulses, all channels blocked (R3, R4)
    fmt_sel = 2'd2; sync_mf = 1'b0; sync_dbl = 1'b0;
    mask_we = 1'b1; mask_wdata = 24'hFFFFFF;
    step();
    mask_we = 1'b0;
    rand_cycles(10000, 0, 1'b1);

    // Sync as input with random pulses (R9)
    sync_drive = 1'b0; fmt_sel = 2'd1;
    while (mb != 192) step();
    sync_mf = 1'b0; sync_in = 1'b1;     // frame pulse at natural frame end
    step();
    sync_in = 1'b0;
    repeat (50) step();
    sync_mf = 1'b1; sync_in = 1'b1;     // multiframe pulse mid-frame
    step();
    sync_in = 1'b0;
    rand_cycles(10000, 400, 1'b1);
    fmt_sel = 2'd3;
    rand_cycles(2000, 300, 1'b1);

    // R10: sync_in toggling while driving the output
    sync_drive = 1'b1; fmt_sel = 2'd1; sync_mf = 1'b0;
    rand_cycles(3000, 3, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule